// File: doc/BRIEF.md
# Staged Byte-Lane Command Register

This block is a 32-bit command register that the host writes through byte enables. The host may write it as one full word, as two half-words or as four single bytes. Bytes that arrive before the top lane only fill a staging word and have no other effect. When a write touches the most significant byte lane, the register commits. The merged word, including the bytes of that same access, is handed on with a one-cycle pulse.

The low bits of the committed word select an action. One code requests a controller reset and another requests an internal self-test. Any other code is taken without effect. While the controller reports itself busy, a committed command is dropped and a rejection pulse is raised in its place. The reset sequence and the self-test are carried out elsewhere. This block only issues the request pulses.

Software therefore has to write the high byte last. A partial update of the low lanes stays in staging until the top lane arrives.

Top module: `cmd_stage_reg`

## Requirements
- R1: After reset all output pulses are low, `commitWord` is zero and the staging word is zero.
- R2: A write updates only the byte lanes whose enable bit is set. Enable bit i covers data bits 8i+7..8i. Every other lane keeps its previous value.
- R3: A write whose enable bit 3 is clear produces no commit pulse, no request and no rejection.
- R4: A write with enable bit 3 set raises `commitPulse` for exactly the single clock cycle that follows the write edge.
- R5: `commitWord` carries the staging word merged with the bytes of the committing write, and holds that value until the next commit.
- R6: A commit whose bits 3:0 equal 4'h1 while `busy` is low pulses `resetReq` together with `commitPulse`.
- R7: A commit whose bits 3:0 equal 4'h2 while `busy` is low pulses `selfTestReq` together with `commitPulse`.
- R8: A commit with any other value in bits 3:0 raises neither request and no rejection.
- R9: A commit while `busy` is high raises no request and pulses `rejected` together with `commitPulse`.
- R10: The staging word is not cleared by a commit. Later partial writes merge into the last committed value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| wrBe | input | 4 | Byte enables, bit i for byte lane i |
| wrData | input | 32 | Host write data |
| busy | input | 1 | Controller busy; commits are rejected while high |
| commitPulse | output | 1 | One-cycle pulse on each commit |
| commitWord | output | 32 | Last committed merged word |
| resetReq | output | 1 | One-cycle controller reset request |
| selfTestReq | output | 1 | One-cycle self-test request |
| rejected | output | 1 | One-cycle pulse for a commit dropped while busy |

## Verification
The assertions assume that `wrEn` comes with one of the aligned enable patterns for a byte, a half-word or the full word. They also assume that `busy` is sampled at the same edge as the committing write. The random stimulus draws enables only from those seven patterns. It biases the low nibble of the data toward the two action codes, so that requests, ignored codes and busy rejections all occur often. Directed cases cover a series of low-lane writes followed by a top-byte commit, and back-to-back commits.

// File: rtl/cmd_stage_pkg.sv
package cmd_stage_pkg;
  typedef struct packed {
    logic stageWr;   // at least one lane written this cycle
    logic commitWr;  // top lane written: capture merged word
  } ctrlStrobes_t;
endpackage

// File: rtl/cmd_stage_dp.sv
module cmd_stage_dp
  import cmd_stage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [DATA_W/8-1:0]     wrBe,
  input  logic [DATA_W-1:0]       wrData,
  output logic [CODE_W-1:0]       mergedCode,
  output logic [DATA_W-1:0]       commitWord
);
  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] stageQ;
  logic [DATA_W-1:0] merged;

  // per-lane merge of incoming bytes over the staging word
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign merged[8*g +: 8] = wrBe[g] ? wrData[8*g +: 8] : stageQ[8*g +: 8];
  end

  assign mergedCode = merged[CODE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else if (strobes.stageWr) begin
      stageQ <= merged;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitWord <= '0;
    end else if (strobes.commitWr) begin
      commitWord <= merged;
    end
  end

  // R2: staging only moves when a lane is written
  a_r2_stage_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.stageWr |=> $stable(stageQ));

  // R5: the committed word holds between commits
  a_r5_word_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.commitWr |=> $stable(commitWord));

  // R10: a commit leaves the staging word equal to the committed word
  a_r10_stage_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commitWr |=> (stageQ == commitWord));
endmodule

// File: rtl/cmd_stage_ctrl.sv
module cmd_stage_ctrl
  import cmd_stage_pkg::*;
#(
  parameter int            LANES         = 4,
  parameter int            CODE_W        = 4,
  parameter logic [CODE_W-1:0] RESET_CODE = 4'h1,
  parameter logic [CODE_W-1:0] TEST_CODE  = 4'h2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [LANES-1:0]   wrBe,
  input  logic               busy,
  input  logic [CODE_W-1:0]  mergedCode,
  output ctrlStrobes_t       strobes,
  output logic               commitPulse,
  output logic               resetReq,
  output logic               selfTestReq,
  output logic               rejected
);
  localparam int TOP_LANE = LANES - 1;

  logic commitNow;
  logic acceptNow;

  assign commitNow        = wrEn && wrBe[TOP_LANE];
  assign acceptNow        = commitNow && !busy;
  assign strobes.stageWr  = wrEn && (|wrBe);
  assign strobes.commitWr = commitNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      commitPulse <= 1'b0;
      resetReq    <= 1'b0;
      selfTestReq <= 1'b0;
      rejected    <= 1'b0;
    end else begin
      commitPulse <= commitNow;
      resetReq    <= acceptNow && (mergedCode == RESET_CODE);
      selfTestReq <= acceptNow && (mergedCode == TEST_CODE);
      rejected    <= commitNow && busy;
    end
  end

  // R3, R4: a pulse follows exactly the edges with a top-lane write
  a_r3_no_commit: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrBe[TOP_LANE]) |=> !commitPulse);
  a_r4_commit: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrBe[TOP_LANE]) |=> commitPulse);

  // R6, R7, R9: at most one action, and every action rides on a commit
  a_r6_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetReq, selfTestReq, rejected}));
  a_r7_action_needs_commit: assert property (@(posedge clk) disable iff (!rstN)
    (resetReq || selfTestReq || rejected) |-> commitPulse);

  // R9: busy at the write edge turns the commit into a rejection
  a_r9_busy_reject: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrBe[TOP_LANE] && busy) |=> (rejected && !resetReq && !selfTestReq));
endmodule

// File: rtl/cmd_stage_reg.sv
module cmd_stage_reg
  import cmd_stage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] RESET_CODE = 4'h1,
  parameter logic [CODE_W-1:0] TEST_CODE  = 4'h2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [DATA_W/8-1:0] wrBe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                busy,
  output logic                commitPulse,
  output logic [DATA_W-1:0]   commitWord,
  output logic                resetReq,
  output logic                selfTestReq,
  output logic                rejected
);
  localparam int LANES = DATA_W / 8;

  ctrlStrobes_t      strobes;
  logic [CODE_W-1:0] mergedCode;

  cmd_stage_ctrl #(
    .LANES(LANES), .CODE_W(CODE_W),
    .RESET_CODE(RESET_CODE), .TEST_CODE(TEST_CODE)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .busy(busy),
    .mergedCode(mergedCode), .strobes(strobes),
    .commitPulse(commitPulse), .resetReq(resetReq),
    .selfTestReq(selfTestReq), .rejected(rejected)
  );

  cmd_stage_dp #(
    .DATA_W(DATA_W), .CODE_W(CODE_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrBe(wrBe),
    .wrData(wrData), .mergedCode(mergedCode), .commitWord(commitWord)
  );
endmodule

// File: tb/test_cmd_stage_reg.sv
module test_cmd_stage_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrBe = '0;
  logic [31:0] wrData = '0;
  logic        busy = 1'b0;
  logic        commitPulse, resetReq, selfTestReq, rejected;
  logic [31:0] commitWord;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model
  logic [31:0] mStage = '0;
  logic [31:0] mWord  = '0;

  always #2 clk = ~clk;

  cmd_stage_reg i_cmd_stage_reg (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrBe(wrBe), .wrData(wrData),
    .busy(busy), .commitPulse(commitPulse), .commitWord(commitWord),
    .resetReq(resetReq), .selfTestReq(selfTestReq), .rejected(rejected)
  );

  function automatic logic [31:0] mergeBytes(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle (possibly idle), then check all outputs from the model
  task automatic cycle(logic en, logic [3:0] be, logic [31:0] d, logic bz, string req);
    logic [31:0] m;
    logic cm, rq, tq, rj;
    @(negedge clk);
    wrEn = en; wrBe = be; wrData = d; busy = bz;
    m  = mergeBytes(mStage, d, be);
    cm = en && be[3];
    rq = cm && !bz && (m[3:0] == 4'h1);
    tq = cm && !bz && (m[3:0] == 4'h2);
    rj = cm && bz;
    if (en) mStage = m;
    if (cm) mWord = m;
    @(negedge clk);
    wrEn = 1'b0; wrBe = '0;
    check({req, " commitPulse"}, {31'd0, commitPulse}, {31'd0, cm});
    check({req, " commitWord"},  commitWord, mWord);
    check({req, " resetReq"},    {31'd0, resetReq},    {31'd0, rq});
    check({req, " selfTestReq"}, {31'd0, selfTestReq}, {31'd0, tq});
    check({req, " rejected"},    {31'd0, rejected},    {31'd0, rj});
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [3:0] bePick [7];
    void'($urandom(32'd1234));
    bePick = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 commitPulse", {31'd0, commitPulse}, 32'd0);
    check("R1 commitWord", commitWord, 32'd0);
    check("R1 requests", {29'd0, resetReq, selfTestReq, rejected}, 32'd0);
    rstN = 1'b1;
    // R1, R10: staging starts at zero, seen through a top-byte commit
    cycle(1, 4'h8, 32'hAB00_0000, 0, "R1");
    // R2, R3: low-lane writes stage without commit
    cycle(1, 4'h1, 32'h0000_0011, 0, "R3");
    cycle(1, 4'h2, 32'h0000_2200, 0, "R3");
    cycle(1, 4'h4, 32'h0033_0000, 0, "R2");
    // R4, R5, R6: top byte completes the word with reset code 1
    cycle(1, 4'h8, 32'h4400_0000, 0, "R5");
    cycle(0, 4'h0, 32'h0, 0, "R4 drop");
    // R7: full-word self-test
    cycle(1, 4'hF, 32'h1234_5602, 0, "R7");
    // R10: upper half only, low bits kept from before -> still self-test code
    cycle(1, 4'hC, 32'hBEEF_0000, 0, "R10");
    // R6: half-word reset code then high half
    cycle(1, 4'h3, 32'h0000_0001, 0, "R6");
    cycle(1, 4'hC, 32'h0101_0000, 0, "R6");
    // R8: unknown code
    cycle(1, 4'hF, 32'h0000_0007, 0, "R8");
    // R9: busy rejection, then back-to-back commit
    cycle(1, 4'hF, 32'h0000_0001, 1, "R9");
    cycle(1, 4'hF, 32'h0000_0002, 0, "R4");
    // R9: busy without top lane has no effect
    cycle(1, 4'h1, 32'h0000_0001, 1, "R3");
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      logic [3:0]  be;
      d = $urandom();
      case ($urandom_range(0, 2))
        0: d[3:0] = 4'h1;
        1: d[3:0] = 4'h2;
        default: ;
      endcase
      be = bePick[$urandom_range(0, 6)];
      cycle($urandom_range(0, 3) != 0, be, d, $urandom_range(0, 3) == 0, "R2 rand");
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule